// File: doc/BRIEF.md
# 32-bit Shift Unit with Zero, Sign and Overflow Flags

This block is the shift execution slice of a small byte-coded integer datapath. Each operation carries a 32-bit operand, two candidate shift counts (the low byte of a count register and an 8-bit immediate), a selector that picks between them, and the 3-bit sub-operation field taken from the middle bits of the addressing byte. The unit shifts the operand left, logically right (zero fill) or arithmetically right (sign fill). It updates the zero, sign and overflow flags according to the rules of the classic 32-bit integer shift group. Any other sub-operation code is reported as illegal and leaves all state as it was.

Operations enter through a valid/ready handshake. The shift network is combinational. The result, an illegal marker and the three flags are captured in a single output stage. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` from the next cycle and holds until a cycle where `out_ready` is high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no loss and no duplication. The flags are plain status outputs. They change only when an operation is accepted.

Top module: `shift_flag_unit`

## Requirements
- R1: Sub-operation code 4 shifts left, code 5 shifts right filling with zeros, and code 7 shifts right filling with the original bit 31. The result appears on `out_result` with `out_valid` high in the cycle after acceptance. Examples: 13 left by 1 gives 0x1A. 26 or 27 right by 1 gives 0x0D in both right modes. 0xFFFFFFFD right by 1 gives 0xFFFFFFFE arithmetically and 0x7FFFFFFE logically.
- R2: The effective count is the selected source ANDed with 0x1F. `use_imm`=1 selects `imm_count`, and `use_imm`=0 selects `reg_count`. The same sub-operation decoding applies to both sources.
- R3: After an accepted legal operation with a nonzero effective count, `flag_zf` is 1 exactly when the 32-bit result is zero.
- R4: After an accepted legal operation with a nonzero effective count, `flag_sf` equals result bit 31 for the left and arithmetic right shifts, and is 0 after a logical right shift.
- R5: `flag_of` is written only when the effective count is 1. Its new value is bit 31 XOR bit 30 of the operand for a left shift, operand bit 31 for a logical right shift, and 0 for an arithmetic right shift. For any other count it keeps its value.
- R6: With an effective count of 0, the result equals the operand and all three flags keep their previous values.
- R7: Sub-operation codes 0, 1, 2, 3 and 6 produce an output beat with `out_illegal`=1, while `out_result` and all flags keep their previous values. A legal beat has `out_illegal`=0.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output beat (`out_result`, `out_illegal`) holds unchanged.
- R9: After reset, `out_valid`, `out_result`, `out_illegal` and all flags are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_operand | input | 32 | Value to shift |
| reg_count | input | 8 | Low byte of the count register |
| imm_count | input | 8 | Immediate count byte |
| use_imm | input | 1 | 1: count from `imm_count`, 0: from `reg_count` |
| subop | input | 3 | Sub-operation code (4 left, 5 logical right, 7 arithmetic right) |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_result | output | 32 | Shifted value |
| out_illegal | output | 1 | The beat came from an unsupported sub-operation code |
| flag_zf | output | 1 | Zero flag |
| flag_sf | output | 1 | Sign flag |
| flag_of | output | 1 | Overflow flag |

## Verification
Every result, illegal marker and flag is due exactly one rising edge after the edge that accepts the operation. Nothing else in the block has latency. The bench drives inputs on the falling edge and waits there until `in_ready` is high, so it knows which rising edge accepts the operation. It then samples all outputs on the following falling edge, half a cycle after they change. The stall scenario holds `out_ready` low over several edges and samples on each falling edge, checking that the beat stays frozen and that no new operation slips in.

// File: rtl/shu_pkg.sv
package shu_pkg;

  // Kind of shift selected by the sub-operation field
  typedef enum logic [1:0] {
    SK_LEFT   = 2'd0,
    SK_LRIGHT = 2'd1,
    SK_ARIGHT = 2'd2,
    SK_NONE   = 2'd3
  } shu_kind_e;

  // Sub-operation encodings; the numeric values are part of the instruction format
  localparam logic [2:0] SUBOP_SHL = 3'd4;
  localparam logic [2:0] SUBOP_SHR = 3'd5;
  localparam logic [2:0] SUBOP_SAR = 3'd7;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } shu_flags_t;

endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
#(
  parameter int SRC_W = 8,
  parameter int CNT_W = 5
) (
  input  logic [2:0]       subop,
  input  logic [SRC_W-1:0] reg_count,
  input  logic [SRC_W-1:0] imm_count,
  input  logic             use_imm,
  output shu_kind_e        kind,
  output logic             legal,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             cnt_one
);

  localparam logic [SRC_W-1:0] CNT_MASK = SRC_W'((1 << CNT_W) - 1);

  logic [SRC_W-1:0] src_sel;
  logic [SRC_W-1:0] src_masked;

  assign src_sel    = use_imm ? imm_count : reg_count;
  assign src_masked = src_sel & CNT_MASK;
  assign cnt        = src_masked[CNT_W-1:0];
  assign cnt_zero   = (src_masked == '0);
  assign cnt_one    = (src_masked == SRC_W'(1));

  always_comb begin
    unique case (subop)
      SUBOP_SHL: kind = SK_LEFT;
      SUBOP_SHR: kind = SK_LRIGHT;
      SUBOP_SAR: kind = SK_ARIGHT;
      default:   kind = SK_NONE;
    endcase
  end

  assign legal = (kind != SK_NONE);

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
  import shu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 5
) (
  input  logic [WIDTH-1:0] operand,
  input  shu_kind_e        kind,
  input  logic [CNT_W-1:0] cnt,
  output logic [WIDTH-1:0] result
);

  logic fill;
  logic [WIDTH-1:0] lstage [0:CNT_W];
  logic [WIDTH-1:0] rstage [0:CNT_W];

  assign fill      = (kind == SK_ARIGHT) & operand[WIDTH-1];
  assign lstage[0] = operand;
  assign rstage[0] = operand;

  // One stage per count bit, each moving by a power of two
  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign lstage[i+1] = cnt[i] ? (lstage[i] << SH) : lstage[i];
    assign rstage[i+1] = cnt[i] ? {{SH{fill}}, rstage[i][WIDTH-1:SH]} : rstage[i];
  end

  assign result = (kind == SK_LEFT) ? lstage[CNT_W] : rstage[CNT_W];

endmodule

// File: rtl/shu_flags.sv
module shu_flags
  import shu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  shu_kind_e        kind,
  input  logic             op_msb,
  input  logic             op_next,
  input  logic [WIDTH-1:0] result,
  input  logic             cnt_zero,
  input  logic             cnt_one,
  input  shu_flags_t       prev,
  output shu_flags_t       next
);

  always_comb begin
    next = prev;
    if (!cnt_zero) begin
      next.zf = (result == '0);
      next.sf = (kind == SK_LRIGHT) ? 1'b0 : result[WIDTH-1];
      if (cnt_one) begin
        unique case (kind)
          SK_LEFT:   next.of = op_msb ^ op_next;
          SK_LRIGHT: next.of = op_msb;
          default:   next.of = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_operand,
  input  logic [SRC_W-1:0] reg_count,
  input  logic [SRC_W-1:0] imm_count,
  input  logic             use_imm,
  input  logic [2:0]       subop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_illegal,
  output logic             flag_zf,
  output logic             flag_sf,
  output logic             flag_of
);

  localparam int CNT_W = $clog2(WIDTH);

  shu_kind_e        kind;
  logic             legal;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             cnt_one;
  logic [WIDTH-1:0] shifted;
  shu_flags_t       flags_q;
  shu_flags_t       flags_d;
  logic             valid_q;
  logic             ill_q;
  logic [WIDTH-1:0] result_q;
  logic             accept;

  shu_decode #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_dec (
    .subop     (subop),
    .reg_count (reg_count),
    .imm_count (imm_count),
    .use_imm   (use_imm),
    .kind      (kind),
    .legal     (legal),
    .cnt       (cnt),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one)
  );

  shu_barrel #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_sh (
    .operand (in_operand),
    .kind    (kind),
    .cnt     (cnt),
    .result  (shifted)
  );

  shu_flags #(.WIDTH(WIDTH)) u_fl (
    .kind     (kind),
    .op_msb   (in_operand[WIDTH-1]),
    .op_next  (in_operand[WIDTH-2]),
    .result   (shifted),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .prev     (flags_q),
    .next     (flags_d)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      ill_q    <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      ill_q   <= !legal;
      if (legal) begin
        result_q <= shifted;
        flags_q  <= flags_d;
      end
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = ill_q;
  assign out_result  = result_q;
  assign flag_zf     = flags_q.zf;
  assign flag_sf     = flags_q.sf;
  assign flag_of     = flags_q.of;

endmodule

// File: rtl/shu_checker.sv
module shu_checker #(
  parameter int WIDTH = 32,
  parameter int SRC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_operand,
  input logic [SRC_W-1:0] reg_count,
  input logic [SRC_W-1:0] imm_count,
  input logic             use_imm,
  input logic [2:0]       subop,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_illegal,
  input logic             flag_zf,
  input logic             flag_sf,
  input logic             flag_of
);

  logic [SRC_W-1:0] eff;
  logic             acc;
  logic             ok_code;

  assign eff     = (use_imm ? imm_count : reg_count) & SRC_W'(WIDTH - 1);
  assign acc     = in_valid && in_ready;
  assign ok_code = (subop == 3'd4) || (subop == 3'd5) || (subop == 3'd7);

  // R1: an accepted operation is presented in the next cycle
  p_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R3: zero flag matches the result
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ok_code && eff != '0) |=> (flag_zf == (out_result == '0)));

  // R4: logical right shift clears sign
  p_sign_lsr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && subop == 3'd5 && eff != '0) |=> !flag_sf);

  // R5: overflow untouched unless the count is one
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ok_code && eff != SRC_W'(1)) |=> $stable(flag_of));

  // R5: arithmetic right by one clears overflow
  p_of_sar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && subop == 3'd7 && eff == SRC_W'(1)) |=> !flag_of);

  // R6: zero count passes the operand and keeps flags
  p_cnt_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ok_code && eff == '0) |=>
      (out_result == $past(in_operand) && $stable(flag_zf) &&
       $stable(flag_sf) && $stable(flag_of)));

  // R7: illegal code marks the beat and changes nothing else
  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ok_code) |=>
      (out_illegal && $stable(out_result) && $stable(flag_zf) &&
       $stable(flag_sf) && $stable(flag_of)));

  // R8: a stalled beat blocks input and holds still
  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_illegal)));

endmodule

bind shift_flag_unit shu_checker #(.WIDTH(WIDTH), .SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_operand  (in_operand),
  .reg_count   (reg_count),
  .imm_count   (imm_count),
  .use_imm     (use_imm),
  .subop       (subop),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal),
  .flag_zf     (flag_zf),
  .flag_sf     (flag_sf),
  .flag_of     (flag_of)
);

// File: tb/sim_shift_flag_unit.sv
module sim_shift_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic [7:0]  reg_count = '0;
  logic [7:0]  imm_count = '0;
  logic        use_imm = 1'b0;
  logic [2:0]  subop = 3'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;
  logic        flag_zf;
  logic        flag_sf;
  logic        flag_of;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shift_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .reg_count(reg_count), .imm_count(imm_count),
    .use_imm(use_imm), .subop(subop), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal),
    .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Offer one operation on a falling edge, wait for acceptance, sample next falling edge
  task automatic run_op(input string tag, input logic [31:0] op, input logic [7:0] rc,
                        input logic [7:0] ic, input logic ui, input logic [2:0] so,
                        input logic [31:0] e_res, input logic e_z, input logic e_s,
                        input logic e_o, input logic e_ill);
    @(negedge clk);
    in_operand = op; reg_count = rc; imm_count = ic; use_imm = ui; subop = so;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"},   {31'd0, out_valid},   32'd1);
    check({tag, " result"},  out_result,           e_res);
    check({tag, " zf"},      {31'd0, flag_zf},     {31'd0, e_z});
    check({tag, " sf"},      {31'd0, flag_sf},     {31'd0, e_s});
    check({tag, " of"},      {31'd0, flag_of},     {31'd0, e_o});
    check({tag, " illegal"}, {31'd0, out_illegal}, {31'd0, e_ill});
  endtask

  task automatic t_reset;
    check("R9 out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 result", out_result, 32'd0);
    check("R9 flags", {29'd0, flag_zf, flag_sf, flag_of}, 32'd0);
    check("R9 illegal", {31'd0, out_illegal}, 32'd0);
    check("R9 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_modes;
    run_op("R1 shl 13",        32'd13,         8'd1, 8'd0, 1'b0, 3'd4, 32'h1A,       1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R5 shl of",        32'h4000_0000,  8'd1, 8'd0, 1'b0, 3'd4, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op("R1 sar 26",        32'd26,         8'd0, 8'd1, 1'b1, 3'd7, 32'h0D,       1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R1 sar 27",        32'd27,         8'd0, 8'd1, 1'b1, 3'd7, 32'h0D,       1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R4 sar neg",       32'hFFFF_FFFD,  8'd0, 8'd1, 1'b1, 3'd7, 32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R1 shr 26",        32'd26,         8'd1, 8'd0, 1'b0, 3'd5, 32'h0D,       1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R4 shr neg",       32'hFFFF_FFFD,  8'd1, 8'd0, 1'b0, 3'd5, 32'h7FFF_FFFE, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_overflow_hold;
    run_op("R5 shr by4 hold",  32'h8000_0000,  8'd0, 8'd4,  1'b1, 3'd5, 32'h0800_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op("R5 sar by31 hold", 32'h8000_0000,  8'd0, 8'h1F, 1'b1, 3'd7, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_count_select;
    run_op("R2 imm mask",      32'd13, 8'd0,  8'h21, 1'b1, 3'd4, 32'h1A, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R2 reg mask",      32'd13, 8'hE4, 8'h01, 1'b0, 3'd4, 32'hD0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R2 imm select",    32'd13, 8'h03, 8'h02, 1'b1, 3'd4, 32'h34, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_and_count0;
    run_op("R3 shl to zero",   32'h8000_0000, 8'd1, 8'd0,  1'b0, 3'd4, 32'h0,    1'b1, 1'b0, 1'b1, 1'b0);
    run_op("R6 count zero",    32'h1234,      8'd1, 8'h20, 1'b1, 3'd5, 32'h1234, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;
    run_op("R7 code 6",        32'h55, 8'd1, 8'd0, 1'b0, 3'd6, 32'h1234, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op("R7 code 0",        32'h0,  8'd2, 8'd0, 1'b0, 3'd0, 32'h1234, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op("R3 shr to zero",   32'h1,  8'd1, 8'd0, 1'b0, 3'd5, 32'h0,    1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = 32'd3; reg_count = 8'd2; use_imm = 1'b0; subop = 3'd4; in_valid = 1'b1;
    @(negedge clk);
    // first beat accepted (stage was empty), now stalled
    check("R8 beat valid", {31'd0, out_valid}, 32'd1);
    check("R8 beat result", out_result, 32'd12);
    check("R8 ready low", {31'd0, in_ready}, 32'd0);
    in_operand = 32'd5; reg_count = 8'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held result", out_result, 32'd12);
      check("R8 held ready", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next beat", out_result, 32'd10);
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_modes();
    t_overflow_hold();
    t_count_select();
    t_zero_and_count0();
    t_illegal();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule